// File: doc/BRIEF.md
# SDRAM Command Decoder and State Tracker

This block watches the control pins of a single-data-rate SDRAM device from the device side. At every rising clock edge it turns the chip-select, row-strobe, column-strobe and write-enable levels into one command. It takes the clock-enable level from that edge and from the edge before into account, and it uses the auto-precharge address bit and the bank select. Each command is checked against per-bank state and the device power state. Legal commands update that state. Illegal commands raise an error strobe and are otherwise ignored.

Each bank runs its own three-state machine. Its states are `BK_IDLE`, `BK_ACTIVE` and `BK_CLOSING`, where the last one means active with an auto-precharge waiting for the burst to end. The transitions are: open on a row activate, close on a precharge, arm on an auto-precharge access, and finish on the burst-end pulse. The device-wide machine has the states `PW_NORMAL`, `PW_PDOWN`, `PW_SREF` and `PW_SUSPEND`. Its transitions are: self-refresh entry, power-down entry, the suspend variant of that entry when a burst is running, and the wake transition back to normal. A burst counter is loaded from the burst length captured at mode register set. It counts down once per normal clock and stops while the clock is suspended.

Command code, legal strobe and error strobe are registered. They describe the command sampled at an edge and are visible in the cycle after that edge. Bank flags, power state and burst indication show the state after the same edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: A synchronous active-low reset leaves all banks idle, power state normal (code 0), burst indication low, both strobes low, data enable low and command code 0.
- R2: With clock-enable high at this edge and at the previous edge, in the normal state, the command codes are as follows. Chip-select high gives 0 (deselect). With chip-select low, the row/column/write strobes decode as: high/high/high is 1 (no-op), low/high/high is 2 (activate), high/low/high is 3 (read) or 4 (read with auto-precharge), high/low/low is 5 (write) or 6 (write with auto-precharge), low/high/low is 7 (precharge one) or 8 (precharge all), low/low/low is 9 (mode set), low/low/high is 10 (auto refresh) and high/high/low is 15 (illegal encoding). For codes 3 to 8, the second code of each pair applies when the auto-precharge address bit is high.
- R3: Activate is legal only when the addressed bank is idle, and it opens that bank.
- R4: Read and write are legal only when the addressed bank is open and no auto-precharge burst is in progress.
- R5: Precharge-one closes the addressed bank and precharge-all closes every bank regardless of the bank bits. Precharge-one of the bank waiting for auto-precharge is illegal, and precharge-all is illegal while any bank is waiting for auto-precharge.
- R6: Mode set and auto refresh are legal only with all banks idle and no burst running. Mode set captures address bits 2..0 as the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a full page. Codes 4 to 6 make the mode set illegal.
- R7: When clock-enable falls in the normal state, the refresh encoding gives code 11. Code 11 is legal only with all banks idle and no burst, and it enters self-refresh (power code 2). A deselect or no-op gives code 12, which enters power-down (code 1), or clock suspend (code 3) if a burst is running. Any other bus gives code 15.
- R8: After a legal read or write, the burst indication stays high for exactly the burst length in cycles. The counter does not advance on the suspend-entry edge, on any edge while suspended, or on the wake edge.
- R9: An auto-precharge access closes its bank on the edge where its burst ends, so the bank flag and the burst indication fall together.
- R10: An illegal command gives error high and legal low for one cycle. It changes no bank, power state or burst length, though a running burst keeps counting.
- R11: Data enable is registered. It is high after an edge where the state was normal, some bank was open and the data mask was low.
- R12: In any low-power state, clock-enable low gives code 14 (hold, legal). Clock-enable high with a deselect or no-op bus gives code 13 (wake, legal, returns to normal). Clock-enable high with any other bus gives code 15 (illegal). In the normal state, an edge whose previous clock-enable was low gives code 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask, high disables data |
| addr | input | ADDR_W | Address bus |
| ba | input | log2(NUM_BANKS) | Bank select |
| cmd_code | output | 4 | Decoded command of the last edge |
| cmd_ok | output | 1 | Last command legal |
| cmd_err | output | 1 | Last command illegal |
| bank_open | output | NUM_BANKS | Per-bank open flag |
| burst_busy | output | 1 | Burst in progress |
| data_en | output | 1 | Data write or output enable |
| pwr_state | output | 2 | 0 normal, 1 power-down, 2 self-refresh, 3 suspend |

## Verification
The bench builds the block with two banks and a 16-beat full page. With that size, every burst-length code, the full page included, finishes within a few dozen cycles. Two banks are enough to tell a single-bank precharge from precharge-all, and an auto-precharge on one bank from activity on the other. All sixteen bus encodings are swept under each clock-enable context: steady high, falling, low-power hold and low-power wake. Each result is checked for code, legality, power state and bank flags.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    typedef enum logic [3:0] {
        CMD_DESEL   = 4'd0,
        CMD_NOP     = 4'd1,
        CMD_ACT     = 4'd2,
        CMD_RD      = 4'd3,
        CMD_RDA     = 4'd4,
        CMD_WR      = 4'd5,
        CMD_WRA     = 4'd6,
        CMD_PRE     = 4'd7,
        CMD_PREA    = 4'd8,
        CMD_MRS     = 4'd9,
        CMD_REF     = 4'd10,
        CMD_SREF_IN = 4'd11,
        CMD_PDN_IN  = 4'd12,
        CMD_LP_EXIT = 4'd13,
        CMD_LP_HOLD = 4'd14,
        CMD_BAD     = 4'd15
    } cmd_e;

    typedef enum logic [1:0] {
        PW_NORMAL  = 2'd0,
        PW_PDOWN   = 2'd1,
        PW_SREF    = 2'd2,
        PW_SUSPEND = 2'd3
    } pwr_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_ACTIVE  = 2'd1,
        BK_CLOSING = 2'd2
    } bank_e;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic lp,
    input  logic cke_prev,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic ap,
    output cmd_e cmd
);
    logic quiet;

    always_comb begin
        quiet = cs_n || (ras_n && cas_n && we_n);
        cmd   = CMD_BAD;
        if (lp) begin
            if (cke) cmd = quiet ? CMD_LP_EXIT : CMD_BAD;
            else     cmd = CMD_LP_HOLD;
        end else begin
            unique case ({cke_prev, cke})
                2'b11: begin
                    if (cs_n) begin
                        cmd = CMD_DESEL;
                    end else begin
                        unique case ({ras_n, cas_n, we_n})
                            3'b111:  cmd = CMD_NOP;
                            3'b011:  cmd = CMD_ACT;
                            3'b101:  cmd = ap ? CMD_RDA  : CMD_RD;
                            3'b100:  cmd = ap ? CMD_WRA  : CMD_WR;
                            3'b010:  cmd = ap ? CMD_PREA : CMD_PRE;
                            3'b000:  cmd = CMD_MRS;
                            3'b001:  cmd = CMD_REF;
                            default: cmd = CMD_BAD;
                        endcase
                    end
                end
                2'b10: begin
                    if (quiet)                                 cmd = CMD_PDN_IN;
                    else if ({ras_n, cas_n, we_n} == 3'b001)   cmd = CMD_SREF_IN;
                    else                                       cmd = CMD_BAD;
                end
                default: cmd = CMD_BAD;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
    import sdcmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic do_open,
    input  logic do_close,
    input  logic arm_ap,
    input  logic burst_end,
    input  logic burst_live,
    output logic is_open,
    output logic ap_pending
);
    bank_e st_q, st_nx;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            BK_IDLE:    if (do_open) st_nx = BK_ACTIVE;
            BK_ACTIVE: begin
                if (do_close)    st_nx = BK_IDLE;
                else if (arm_ap) st_nx = BK_CLOSING;
            end
            BK_CLOSING: if (burst_end) st_nx = BK_IDLE;
            default:    st_nx = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BK_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        is_open    = (st_q != BK_IDLE);
        ap_pending = (st_q == BK_CLOSING);
    end

    // R9: a bank waiting for auto-precharge always has its burst running
    p_closing_needs_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_CLOSING) |-> burst_live);
endmodule

// File: rtl/sdcmd_burst.sv
module sdcmd_burst #(
    parameter  int FULL_PAGE = 256,
    localparam int CNT_W     = $clog2(FULL_PAGE + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_len,
    input  logic [2:0] len_code,
    input  logic       load,
    input  logic       run,
    output logic       busy,
    output logic       last
);
    logic [CNT_W-1:0] len_q, remain_q;

    function automatic logic [CNT_W-1:0] code_len(input logic [2:0] c);
        unique case (c)
            3'd0:    return CNT_W'(1);
            3'd1:    return CNT_W'(2);
            3'd2:    return CNT_W'(4);
            3'd3:    return CNT_W'(8);
            default: return CNT_W'(FULL_PAGE);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= CNT_W'(1);
            remain_q <= '0;
        end else begin
            if (set_len) len_q <= code_len(len_code);
            if (load)                          remain_q <= len_q;
            else if (run && remain_q != '0)    remain_q <= remain_q - CNT_W'(1);
        end
    end

    always_comb begin
        busy = (remain_q != '0);
        last = run && !load && (remain_q == CNT_W'(1));
    end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    parameter  int ADDR_W    = 12,
    parameter  int AP_BIT    = 10,
    parameter  int FULL_PAGE = 256,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 dqm,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BANK_W-1:0]    ba,
    output logic [3:0]           cmd_code,
    output logic                 cmd_ok,
    output logic                 cmd_err,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 burst_busy,
    output logic                 data_en,
    output logic [1:0]           pwr_state
);
    logic                 cke_q;
    cmd_e                 cmd_now, cmd_q;
    pwr_e                 pwr_q, pwr_nx;
    logic [NUM_BANKS-1:0] open_v, pend_v;
    logic [NUM_BANKS-1:0] do_open, do_close, arm_ap;
    logic                 legal, ok_q, err_q, de_q;
    logic                 all_idle, ap_busy, mode_ok, is_col;
    logic                 busy, bend, load, run, set_len;
    logic                 unused_addr;

    assign unused_addr = ^addr;

    sdcmd_decode u_dec (
        .lp       (pwr_q != PW_NORMAL),
        .cke_prev (cke_q),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ap       (addr[AP_BIT]),
        .cmd      (cmd_now)
    );

    always_comb begin
        all_idle = (open_v == '0);
        ap_busy  = |pend_v;
        mode_ok  = !(addr[2:0] inside {3'd4, 3'd5, 3'd6});
        is_col   = (cmd_now inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA});
    end

    // legality against bank and power state
    always_comb begin
        legal = 1'b0;
        unique case (pwr_q)
            PW_NORMAL: begin
                unique case (cmd_now)
                    CMD_DESEL, CMD_NOP, CMD_PDN_IN: legal = 1'b1;
                    CMD_ACT:                        legal = !open_v[ba];
                    CMD_RD, CMD_RDA, CMD_WR, CMD_WRA:
                                                    legal = open_v[ba] && !ap_busy;
                    CMD_PRE:                        legal = !pend_v[ba];
                    CMD_PREA:                       legal = !ap_busy;
                    CMD_MRS:                        legal = all_idle && !busy && mode_ok;
                    CMD_REF, CMD_SREF_IN:           legal = all_idle && !busy;
                    default:                        legal = 1'b0;
                endcase
            end
            default: legal = (cmd_now == CMD_LP_EXIT) || (cmd_now == CMD_LP_HOLD);
        endcase
    end

    // power state transitions
    always_comb begin
        pwr_nx = pwr_q;
        if (legal) begin
            unique case (pwr_q)
                PW_NORMAL: begin
                    if (cmd_now == CMD_SREF_IN)     pwr_nx = PW_SREF;
                    else if (cmd_now == CMD_PDN_IN) pwr_nx = busy ? PW_SUSPEND : PW_PDOWN;
                end
                default: if (cmd_now == CMD_LP_EXIT) pwr_nx = PW_NORMAL;
            endcase
        end
    end

    always_comb begin
        load    = legal && is_col;
        set_len = legal && (cmd_now == CMD_MRS);
        run     = (pwr_q == PW_NORMAL) && !(legal && cmd_now == CMD_PDN_IN);
    end

    sdcmd_burst #(.FULL_PAGE(FULL_PAGE)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_len  (set_len),
        .len_code (addr[2:0]),
        .load     (load),
        .run      (run),
        .busy     (busy),
        .last     (bend)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        always_comb begin
            do_open[i]  = legal && (cmd_now == CMD_ACT) && (ba == BANK_W'(i));
            do_close[i] = legal && (((cmd_now == CMD_PRE) && (ba == BANK_W'(i)))
                                    || (cmd_now == CMD_PREA));
            arm_ap[i]   = legal && ((cmd_now == CMD_RDA) || (cmd_now == CMD_WRA))
                                && (ba == BANK_W'(i));
        end

        sdcmd_bank u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_open    (do_open[i]),
            .do_close   (do_close[i]),
            .arm_ap     (arm_ap[i]),
            .burst_end  (bend),
            .burst_live (busy),
            .is_open    (open_v[i]),
            .ap_pending (pend_v[i])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= PW_NORMAL;
            cke_q <= 1'b1;
        end else begin
            pwr_q <= pwr_nx;
            cke_q <= cke;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_DESEL;
            ok_q  <= 1'b0;
            err_q <= 1'b0;
            de_q  <= 1'b0;
        end else begin
            cmd_q <= cmd_now;
            ok_q  <= legal;
            err_q <= !legal;
            de_q  <= (pwr_q == PW_NORMAL) && (|open_v) && !dqm;
        end
    end

    always_comb begin
        cmd_code   = cmd_q;
        cmd_ok     = ok_q;
        cmd_err    = err_q;
        bank_open  = open_v;
        burst_busy = busy;
        data_en    = de_q;
        pwr_state  = pwr_q;
    end

    // R10: a rejected command leaves the power state as it was
    p_err_holds_power_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (pwr_q == $past(pwr_q)));

    // R6: an accepted mode set was issued with every bank idle
    p_mrs_all_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_q == CMD_MRS) |-> ($past(open_v) == '0));

    // R12: an accepted wake returns the device to normal
    p_wake_to_normal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_q == CMD_LP_EXIT) |-> (pwr_q == PW_NORMAL));

    // R8: clock suspend only exists while a burst is held
    p_suspend_in_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_q == PW_SUSPEND) |-> busy);
endmodule

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b1;
    logic [11:0] addr = '0;
    logic [0:0]  ba = '0;
    logic [3:0]  cmd_code;
    logic        cmd_ok, cmd_err, burst_busy, data_en;
    logic [1:0]  bank_open;
    logic [1:0]  pwr_state;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    sdram_cmd_tracker #(.NUM_BANKS(2), .ADDR_W(12), .AP_BIT(10), .FULL_PAGE(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .dqm(dqm), .addr(addr), .ba(ba), .cmd_code(cmd_code), .cmd_ok(cmd_ok),
        .cmd_err(cmd_err), .bank_open(bank_open), .burst_busy(burst_busy), .data_en(data_en),
        .pwr_state(pwr_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic ck, input logic [3:0] bus, input logic dq,
                         input logic [11:0] a, input logic b);
        @(negedge clk);
        cke = ck; cs_n = bus[3]; ras_n = bus[2]; cas_n = bus[1]; we_n = bus[0];
        dqm = dq; addr = a; ba = b;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();                       drive(1'b1, 4'b0111, 1'b1, 12'd0, 1'b0); endtask
    task automatic act(input logic b);          drive(1'b1, 4'b0011, 1'b1, 12'd0, b);    endtask
    task automatic rd(input logic b, input logic ap);
        drive(1'b1, 4'b0101, 1'b1, {1'b0, ap, 10'd0}, b);
    endtask
    task automatic pre(input logic b, input logic ap);
        drive(1'b1, 4'b0010, 1'b1, {1'b0, ap, 10'd0}, b);
    endtask
    task automatic mrs(input int code);         drive(1'b1, 4'b0000, 1'b1, 12'(code), 1'b0); endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) nop();
        rst_n = 1'b1;
    endtask

    function automatic int exp_code(input bit lp, input bit ckp, input bit ckn,
                                    input bit [3:0] v, input bit ap);
        bit quiet;
        quiet = v[3] || (v[2:0] == 3'b111);
        if (lp) return ckn ? (quiet ? 13 : 15) : 14;
        if (!ckp) return 15;
        if (!ckn) return quiet ? 12 : ((v[3:0] == 4'b0001) ? 11 : 15);
        if (v[3]) return 0;
        case (v[2:0])
            3'b111:  return 1;
            3'b011:  return 2;
            3'b101:  return ap ? 4 : 3;
            3'b100:  return ap ? 6 : 5;
            3'b010:  return ap ? 8 : 7;
            3'b000:  return 9;
            3'b001:  return 10;
            default: return 15;
        endcase
    endfunction

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (R1..R12 run) actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int code, cnt, exp_len;
        bit leg;

        // R1 reset state
        do_reset();
        chk("R1 code", int'(cmd_code), 0);
        chk("R1 ok/err", int'({cmd_ok, cmd_err}), 0);
        chk("R1 banks", int'(bank_open), 0);
        chk("R1 power", int'(pwr_state), 0);
        chk("R1 busy/data_en", int'({burst_busy, data_en}), 0);

        // R2 R7 R12: sweep every bus encoding under every clock-enable context
        for (int ctx = 0; ctx < 4; ctx++) begin
            for (int v = 0; v < 16; v++) begin
                bit lp, ckn;
                lp  = (ctx < 2);
                ckn = ctx[0];
                do_reset();
                if (lp) drive(1'b0, 4'b0111, 1'b1, 12'd0, 1'b0);
                if (lp) chk("R7 enter power-down", int'(pwr_state), 1);
                drive(ckn, 4'(v), 1'b1, 12'd0, 1'b0);
                code = exp_code(lp, 1'b1, ckn, 4'(v), 1'b0);
                chk(lp ? "R12 low-power code" : "R2 decode code", int'(cmd_code), code);
                if (lp) leg = (code == 13 || code == 14);
                else    leg = !(code == 3 || code == 5 || code == 15);
                chk("R10 error strobe", int'(cmd_err), leg ? 0 : 1);
                chk("R10 legal strobe", int'(cmd_ok), leg ? 1 : 0);
                if (lp) chk("R12 power", int'(pwr_state), (code == 13) ? 0 : 1);
                else    chk("R7 power", int'(pwr_state), (code == 11) ? 2 : (code == 12) ? 1 : 0);
                chk("R3 bank flags", int'(bank_open), (code == 2) ? 1 : 0);
            end
        end

        // R6 R8: burst length per mode code; reserved codes keep the old length (R10)
        for (int c = 0; c < 8; c++) begin
            do_reset();
            mrs(1);
            mrs(c);
            chk("R6 mode set legality", int'(cmd_err), (c >= 4 && c <= 6) ? 1 : 0);
            case (c)
                0: exp_len = 1;  1: exp_len = 2;  2: exp_len = 4;  3: exp_len = 8;
                7: exp_len = 16; default: exp_len = 2;
            endcase
            act(1'b0);
            rd(1'b0, 1'b0);
            chk("R4 read legal", int'(cmd_ok), 1);
            cnt = 0;
            while (burst_busy && cnt < 40) begin
                cnt++;
                nop();
            end
            chk("R8 burst length", cnt, exp_len);
        end

        // R9 R4 R5: auto-precharge closes bank 1 as its burst ends
        do_reset();
        mrs(2);
        act(1'b1);
        chk("R3 open bank 1", int'(bank_open), 2);
        rd(1'b1, 1'b1);
        chk("R2 read auto-precharge code", int'(cmd_code), 4);
        chk("R9 busy after access", int'(burst_busy), 1);
        pre(1'b0, 1'b1);
        chk("R5 precharge-all during auto-precharge", int'(cmd_err), 1);
        chk("R10 banks kept", int'(bank_open), 2);
        rd(1'b1, 1'b0);
        chk("R4 access during auto-precharge", int'(cmd_err), 1);
        nop();
        chk("R9 last beat open", int'({bank_open[1], burst_busy}), 3);
        nop();
        chk("R9 closed with burst end", int'({bank_open[1], burst_busy}), 0);

        // R8: clock suspend freezes the burst
        do_reset();
        mrs(3);
        act(1'b0);
        rd(1'b0, 1'b0);
        nop();
        nop();
        drive(1'b0, 4'b0111, 1'b1, 12'd0, 1'b0);
        chk("R7 suspend during burst", int'(pwr_state), 3);
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 4'b0111, 1'b1, 12'd0, 1'b0);
            chk("R8 held in suspend", int'({pwr_state, burst_busy}), 7);
        end
        nop();
        chk("R12 wake from suspend", int'(pwr_state), 0);
        cnt = 0;
        while (burst_busy && cnt < 40) begin
            cnt++;
            nop();
        end
        chk("R8 remaining after suspend", cnt, 6);

        // R3 R5 R6 R7 R10 R11 R12: bank and power rules
        do_reset();
        act(1'b1);
        act(1'b1);
        chk("R3 activate open bank", int'(cmd_err), 1);
        chk("R10 bank unchanged", int'(bank_open), 2);
        act(1'b0);
        chk("R3 both open", int'(bank_open), 3);
        mrs(0);
        chk("R6 mode set with open bank", int'(cmd_err), 1);
        drive(1'b1, 4'b0001, 1'b1, 12'd0, 1'b0);
        chk("R6 refresh with open bank", int'(cmd_err), 1);
        drive(1'b0, 4'b0001, 1'b1, 12'd0, 1'b0);
        chk("R7 self-refresh with open bank", int'({cmd_err, pwr_state}), 4);
        nop();
        chk("R12 normal after low clock-enable", int'({cmd_code, cmd_err}), 31);
        drive(1'b1, 4'b0111, 1'b0, 12'd0, 1'b0);
        chk("R11 data enabled", int'(data_en), 1);
        drive(1'b1, 4'b0111, 1'b1, 12'd0, 1'b0);
        chk("R11 data masked", int'(data_en), 0);
        pre(1'b0, 1'b0);
        chk("R5 precharge one", int'(bank_open), 2);
        pre(1'b0, 1'b1);
        chk("R5 precharge all ignores bank bits", int'(bank_open), 0);
        drive(1'b1, 4'b0111, 1'b0, 12'd0, 1'b0);
        chk("R11 no data when idle", int'(data_en), 0);
        act(1'b0);
        drive(1'b0, 4'b1111, 1'b1, 12'd0, 1'b0);
        chk("R7 power-down while active", int'(pwr_state), 1);
        drive(1'b1, 4'b0011, 1'b1, 12'd0, 1'b1);
        chk("R12 command in power-down", int'({cmd_code, cmd_err}), 31);
        chk("R10 still powered down", int'({pwr_state, bank_open}), 5);
        drive(1'b1, 4'b1111, 1'b1, 12'd0, 1'b0);
        chk("R12 wake", int'({cmd_code, pwr_state}), 52);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule